// File: doc/BRIEF.md
# Paged segment address translator

This block maps a 32-bit virtual address onto a physical address. The two top address bits pick one of four segments. Each segment has its own page table in memory, described by a base register and a length register. The block takes one request at a time over a valid/ready handshake. It bounds-checks the page index against the segment length. It then reads one 32-bit page-table entry over a memory read port with a handshake. It checks the entry's valid and permission bits against the access type and privilege. Finally it returns either the physical address or a fault code.

Segments 0 and 2 grow upward, and segments 1 and 3 grow downward. For a downward segment, the page index counts back from the top of the segment's virtual range, and its table is laid out backward from its base register. A context switch is simply a rewrite of the four base and length pairs through the configuration port. No other state inside the block belongs to a process.

Top module: `seg_page_xlate`

## Requirements
- R1: For segments 0 and 2 (VA[31:30] even), the page index is VA[29:12] and the entry is read at base + 4*index.
- R2: For segments 1 and 3 (VA[31:30] odd), the page index is 0x3FFFF - VA[29:12] and the entry is read at base - 4*(index+1), so the base marks one byte past the table's end.
- R3: An index not less than the segment's length register gives fault code 1. In that case no memory read is issued.
- R4: On success the fault code is 0 and the physical address is {entry[31:12], VA[11:0]}.
- R5: An entry with bit 0 (valid) clear gives fault code 2. This takes priority over permission checks.
- R6: Kind is 0 for read, 1 for write and 2 for fetch. A write needs entry bit 1, a fetch needs bit 3, and a user access (user flag 1) needs bit 2. Any failed check gives fault code 3. A supervisor access skips only the bit 2 check.
- R7: Every faulting response carries a physical address of 0.
- R8: Only one translation is in flight, so req_ready is low while busy. Any wait on the memory port is tolerated. The memory request and the response hold steady until accepted.
- R9: In a configuration write, cfg_addr[2:1] selects the segment, and cfg_addr[0] selects base (0) or length (1). A write made after a request is accepted does not affect that translation. It does affect the next one.
- R10: After reset, req_ready is 1, rsp_valid and mem_req_valid are 0, and all base and length registers are 0. A first translation therefore gives fault code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 user, 0 supervisor |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_pa | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 length, 2 invalid, 3 protection |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 32 | Entry byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page-table entry |
| cfg_we | input | 1 | Segment register write |
| cfg_addr | input | 3 | Segment and base/length select |
| cfg_wdata | input | 32 | Register value |

## Verification
The bench targets the edges of both table directions. These are the last legal index and the first out-of-range index in an upward and a downward segment, and the topmost page of a downward segment at index 0. A design that mixed up the directions, or got the end offset wrong by one entry, would read the wrong memory word or let an out-of-range page through. It also covers an invalid entry that also lacks permissions, and a supervisor access to a page without user permission. Getting either wrong would show up as a wrong fault code. A configuration write placed in mid-translation, together with stalls on every handshake, would expose a design that reads its segment registers late or drops a held response.

// File: rtl/seg_page_xlate.sv
module seg_page_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [1:0]  req_kind,
  input  logic        req_user,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_pa,
  output logic [1:0]  rsp_fault,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata
);
  localparam int OFS_W = 12;
  localparam int IDX_W = 30 - OFS_W;
  localparam logic [1:0] K_WR = 2'd1, K_EX = 2'd2;
  localparam logic [1:0] F_NONE = 2'd0, F_LEN = 2'd1, F_INV = 2'd2, F_PROT = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_MREQ, S_MWAIT, S_RESP} st_t;
  st_t st;

  logic [31:0] base_q [4];
  logic [31:0] len_q  [4];
  logic [1:0]  kind_q;
  logic        user_q;
  logic [OFS_W-1:0] ofs_q;
  logic [31:0] addr_q, pa_q;
  logic [1:0]  flt_q;

  wire [1:0]       seg  = req_va[31:30];
  wire [IDX_W-1:0] pg   = req_va[29:OFS_W];
  wire             down = seg[0];
  wire [IDX_W-1:0] idx  = down ? ({IDX_W{1'b1}} - pg) : pg;
  wire [31:0]      step = {{(30-IDX_W){1'b0}}, idx, 2'b00};
  wire [31:0]      ent  = down ? (base_q[seg] - step - 32'd4) : (base_q[seg] + step);
  wire             len_bad = {{(32-IDX_W){1'b0}}, idx} >= len_q[seg];

  wire pv = mem_rsp_data[0];
  wire pw = mem_rsp_data[1];
  wire pu = mem_rsp_data[2];
  wire px = mem_rsp_data[3];
  wire prot_bad = (kind_q == K_WR && !pw) || (kind_q == K_EX && !px) || (user_q && !pu);

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_MREQ);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (st == S_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr[0]) len_q[cfg_addr[2:1]]  <= cfg_wdata;
      else             base_q[cfg_addr[2:1]] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      kind_q <= '0;
      user_q <= 1'b0;
      ofs_q <= '0;
      addr_q <= '0;
      pa_q <= '0;
      flt_q <= F_NONE;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          kind_q <= req_kind;
          user_q <= req_user;
          ofs_q  <= req_va[OFS_W-1:0];
          addr_q <= ent;
          if (len_bad) begin
            pa_q  <= '0;
            flt_q <= F_LEN;
            st    <= S_RESP;
          end else begin
            st <= S_MREQ;
          end
        end
        S_MREQ: if (mem_req_ready) st <= S_MWAIT;
        S_MWAIT: if (mem_rsp_valid) begin
          st <= S_RESP;
          if (!pv) begin
            pa_q <= '0; flt_q <= F_INV;
          end else if (prot_bad) begin
            pa_q <= '0; flt_q <= F_PROT;
          end else begin
            pa_q <= {mem_rsp_data[31:OFS_W], ofs_q}; flt_q <= F_NONE;
          end
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != F_NONE) |-> rsp_pa == 32'd0);
  a_r8_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_req_valid, rsp_valid}));
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)));
  a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r3_len_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && len_bad) |=> (rsp_valid && rsp_fault == F_LEN));
  a_r5_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MWAIT && mem_rsp_valid && !pv) |=> (rsp_valid && rsp_fault == F_INV));
endmodule

// File: tb/tb_seg_page_xlate.sv
module tb_seg_page_xlate;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_user = 0, rsp_ready = 0, mem_req_ready = 0, mem_rsp_valid = 0, cfg_we = 0;
  logic [31:0] req_va = 0, mem_rsp_data = 0, cfg_wdata = 0;
  logic [1:0] req_kind = 0;
  logic [2:0] cfg_addr = 0;
  logic req_ready, rsp_valid, mem_req_valid;
  logic [31:0] rsp_pa, mem_req_addr;
  logic [1:0] rsp_fault;
  int checks = 0, errors = 0;
  logic [31:0] bb [4];

  always #10 clk = ~clk;

  seg_page_xlate dut (.*);

  localparam int N = 12;
  localparam logic [31:0] T_VA [N] = '{32'h00002123, 32'h00005000, 32'h7FFFF444, 32'h7FFFD000,
    32'h7FFFC000, 32'h80010010, 32'h80000000, 32'h80000FFF, 32'h80000FFF, 32'hFFFFF000,
    32'hFFFFE000, 32'h80001ABC};
  localparam logic [1:0] T_KIND [N] = '{0, 0, 1, 2, 0, 1, 1, 0, 0, 2, 0, 1};
  localparam logic T_USER [N] = '{1, 1, 0, 1, 1, 1, 1, 1, 0, 0, 0, 1};
  localparam logic [3:0] T_FLG [N] = '{4'h5, 4'h5, 4'h3, 4'hD, 4'hF, 4'h5, 4'h0, 4'h1, 4'h1, 4'h3, 4'hF, 4'hF};
  localparam logic [1:0] T_FLT [N] = '{0, 1, 0, 0, 1, 3, 2, 3, 0, 3, 1, 0};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    if (a[0] == 0) bb[a[2:1]] = d;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] va);
    logic [17:0] pg = va[29:12];
    if (!va[30]) return bb[va[31:30]] + {12'd0, pg, 2'b00};
    return bb[va[31:30]] - {12'd0, 18'h3FFFF - pg, 2'b00} - 32'd4;
  endfunction

  task automatic xlate(input logic [31:0] va, input logic [1:0] kind, input logic usr,
                       input logic [3:0] flg, input int lat, input bit midcfg,
                       output bit rd, output logic [31:0] ad, output logic [31:0] pa,
                       output logic [1:0] flt);
    logic [31:0] pa0; logic [1:0] f0;
    rd = 0; ad = 0;
    @(negedge clk); req_valid = 1; req_va = va; req_kind = kind; req_user = usr;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    if (midcfg) begin cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = 32'h9000; bb[0] = 32'h9000;
      @(negedge clk); cfg_we = 0; end
    while (!rsp_valid && !mem_req_valid) @(negedge clk);
    if (mem_req_valid) begin
      rd = 1; ad = mem_req_addr;
      check(!req_ready, "R8 busy", {31'd0, req_ready}, 0);
      repeat (lat) @(negedge clk);
      check(mem_req_valid && mem_req_addr == ad, "R8 memhold", mem_req_addr, ad);
      mem_req_ready = 1; @(negedge clk); mem_req_ready = 0;
      repeat (lat) @(negedge clk);
      mem_rsp_data = {ad[21:2] ^ 20'hABCDE, 8'h00, flg}; mem_rsp_valid = 1;
      @(negedge clk); mem_rsp_valid = 0;
    end
    while (!rsp_valid) @(negedge clk);
    pa0 = rsp_pa; f0 = rsp_fault;
    repeat (lat) @(negedge clk);
    check(rsp_valid && rsp_pa == pa0 && rsp_fault == f0, "R8 rsphold", rsp_pa, pa0);
    pa = rsp_pa; flt = rsp_fault;
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
  endtask

  task automatic run(input logic [31:0] va, input logic [1:0] kind, input logic usr,
                     input logic [3:0] flg, input logic [1:0] ef, input int lat, input bit midcfg);
    bit rd; logic [31:0] ad, pa, ea, epa; logic [1:0] flt;
    ea = exp_addr(va);
    xlate(va, kind, usr, flg, lat, midcfg, rd, ad, pa, flt);
    epa = (ef == 0) ? {ea[21:2] ^ 20'hABCDE, va[11:0]} : 32'd0;
    if (ef == 1) check(!rd, "R3 no read on length fault", {31'd0, rd}, 0);
    else check(rd && ad == ea, va[30] ? "R2 down entry addr" : "R1 up entry addr", ad, ea);
    check(flt == ef, ef == 1 ? "R3 fault" : ef == 2 ? "R5 fault" : ef == 3 ? "R6 fault" : "R4 fault", flt, ef);
    check(pa == epa, ef == 0 ? "R4 pa" : "R7 pa zero", pa, epa);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) bb[i] = 0;
    repeat (2) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R10 reset outputs",
          {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1;
    run(32'h00000010, 0, 0, 4'hF, 1, 0, 0);
    cfg(3'd0, 32'h1000); cfg(3'd1, 5);
    cfg(3'd2, 32'h20000); cfg(3'd3, 3);
    cfg(3'd4, 32'h8000); cfg(3'd5, 32'h40000);
    cfg(3'd6, 32'h30000); cfg(3'd7, 1);
    for (int i = 0; i < N; i++)
      run(T_VA[i], T_KIND[i], T_USER[i], T_FLG[i], T_FLT[i], i % 4, 0);
    bb[0] = 32'h1000;
    run(32'h00004000, 0, 0, 4'h1, 0, 3, 1);
    run(32'h00004000, 0, 0, 4'h1, 0, 0, 0);
    check(bb[0] == 32'h9000, "R9 new base used", bb[0], 32'h9000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule